// File: doc/BRIEF.md
# Colour Lookup Table Loader

This block holds a 256-entry palette of 24-bit colours and offers two sides. On the bus side, software first writes an entry number into an index register and then streams colour bytes into a data register; each byte lands in the red, green or blue component of the selected entry, in that rotation. After a blue byte the entry number steps forward by one and wraps past 255 to 0, so a whole palette loads with one index write followed by a continuous byte stream.

A data write may be one byte, taken from bits 7:0, or a full 32-bit word, which is split into four bytes and fed through the rotation most significant byte first. The word is consumed over four internal cycles, and a busy output asks the bus to hold off while that happens. Every accepted data write raises a one-cycle repaint pulse so a display engine can redraw the whole screen. On the pixel side, an 8-bit pixel value selects an entry and the registered 24-bit colour appears one cycle later.

Top module: `clut_loader`

## Requirements
- R1: A write to offset 0x0 loads bits 7:0 of the write data as the current entry number and returns the component rotation to red.
- R2: A byte-sized write to offset 0x4 stores bits 7:0 into the current component of the current entry; the rotation then steps red, green, blue.
- R3: Storing a blue component advances the entry number by one modulo 256 and returns the rotation to red.
- R4: A word-sized write to offset 0x4 stores bits 31:24, 23:16, 15:8 and 7:0 as four successive components, one per cycle starting in the accepting cycle; busy is high for exactly the three cycles after acceptance.
- R5: Any write presented while busy is high is ignored: it changes neither entries, index, rotation nor the repaint output.
- R6: The read data output is zero at all times, for both registers.
- R7: Synchronous reset clears all 256 entries to zero, sets the entry number to 0 and the rotation to red, and drives busy, repaint and the colour output low.
- R8: The colour output is {red, green, blue} of the entry selected by the pixel input at the previous clock edge, red in bits 23:16; a component stored at that same edge is not yet visible.
- R9: The repaint output is high for exactly the cycle after each accepted write to offset 0x4, and low after index writes, ignored writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, accepted when busy is low |
| bus_addr | input | 3 | Register offset: 0x0 index, 0x4 colour data |
| bus_word | input | 1 | 1 = 32-bit write, 0 = byte write (bits 7:0) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, always zero |
| bus_busy | output | 1 | High while a word write is still being consumed |
| pix_idx | input | 8 | Pixel value to translate |
| pix_rgb | output | 24 | Registered colour of the selected entry |
| repaint_req | output | 1 | One-cycle pulse after each accepted colour write |

## Verification
The assertions take for granted that reset is held across at least one clock edge before any check counts and that the bus inputs carry known values at every edge; they do not assume the bus honours busy, since acceptance is qualified with busy inside each property. The stimulus drives every input from time zero and changes it only just after a rising edge. It deliberately issues writes while busy to reach the ignored case, and its random phase mixes index writes, byte writes and word writes at random offsets, including unused ones, while a behavioural model tracks the expected colour, busy, repaint and read data on every cycle.

// File: rtl/clut_pkg.sv
package clut_pkg;

    localparam int COMP_W   = 8;
    localparam int N_COMP   = 3;
    localparam int OFS_W    = 3;
    localparam logic [OFS_W-1:0] OFS_INDEX = 3'h0;
    localparam logic [OFS_W-1:0] OFS_COLOR = 3'h4;

    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } comp_phase_e;

    function automatic comp_phase_e next_phase(comp_phase_e p);
        case (p)
            PH_RED:  return PH_GRN;
            PH_GRN:  return PH_BLU;
            default: return PH_RED;
        endcase
    endfunction

endpackage

// File: rtl/clut_seq.sv
module clut_seq
    import clut_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int BUS_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic [OFS_W-1:0]   bus_addr,
    input  logic               bus_word,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic               bus_busy,
    output logic               repaint_q,
    output logic [N_COMP-1:0]  comp_we,
    output logic [IDX_W-1:0]   wr_idx,
    output logic [COMP_W-1:0]  wr_byte
);
    localparam int NB    = BUS_W / COMP_W;
    localparam int CNT_W = $clog2(NB);

    logic [IDX_W-1:0] idx_q;
    comp_phase_e      phase_q;
    logic [CNT_W-1:0] left_q;
    logic [BUS_W-1:0] shift_q;

    logic accept, acc_idx, acc_col, emit;

    assign bus_busy = (left_q != '0);
    assign accept   = bus_wr && !bus_busy;
    assign acc_idx  = accept && (bus_addr == OFS_INDEX);
    assign acc_col  = accept && (bus_addr == OFS_COLOR);
    assign emit     = bus_busy || acc_col;

    always_comb begin
        if (bus_busy)
            wr_byte = shift_q[BUS_W-1 -: COMP_W];
        else if (bus_word)
            wr_byte = bus_wdata[BUS_W-1 -: COMP_W];
        else
            wr_byte = bus_wdata[COMP_W-1:0];
    end

    always_comb begin
        comp_we = '0;
        if (emit)
            comp_we[phase_q] = 1'b1;
    end

    assign wr_idx = idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q     <= '0;
            phase_q   <= PH_RED;
            left_q    <= '0;
            shift_q   <= '0;
            repaint_q <= 1'b0;
        end else begin
            repaint_q <= acc_col;
            if (acc_idx) begin
                idx_q   <= bus_wdata[IDX_W-1:0];
                phase_q <= PH_RED;
            end else if (emit) begin
                phase_q <= next_phase(phase_q);
                if (phase_q == PH_BLU)
                    idx_q <= idx_q + 1'b1;
            end
            if (bus_busy) begin
                left_q  <= left_q - 1'b1;
                shift_q <= shift_q << COMP_W;
            end else if (acc_col && bus_word) begin
                left_q  <= CNT_W'(NB - 1);
                shift_q <= bus_wdata << COMP_W;
            end
        end
    end

endmodule

// File: rtl/clut_bank.sv
module clut_bank
    import clut_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [COMP_W-1:0] wbyte,
    input  logic [IDX_W-1:0]  ridx,
    output logic [COMP_W-1:0] rbyte
);
    localparam int DEPTH = 1 << IDX_W;

    logic [COMP_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
            rbyte <= '0;
        end else begin
            if (we)
                mem[widx] <= wbyte;
            rbyte <= mem[ridx];
        end
    end

endmodule

// File: rtl/clut_loader.sv
module clut_loader
    import clut_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int BUS_W = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_wr,
    input  logic [OFS_W-1:0]         bus_addr,
    input  logic                     bus_word,
    input  logic [BUS_W-1:0]         bus_wdata,
    output logic [BUS_W-1:0]         bus_rdata,
    output logic                     bus_busy,
    input  logic [IDX_W-1:0]         pix_idx,
    output logic [N_COMP*COMP_W-1:0] pix_rgb,
    output logic                     repaint_req
);
    logic [N_COMP-1:0] comp_we;
    logic [IDX_W-1:0]  wr_idx;
    logic [COMP_W-1:0] wr_byte;

    assign bus_rdata = '0;

    clut_seq #(.IDX_W(IDX_W), .BUS_W(BUS_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_word  (bus_word),
        .bus_wdata (bus_wdata),
        .bus_busy  (bus_busy),
        .repaint_q (repaint_req),
        .comp_we   (comp_we),
        .wr_idx    (wr_idx),
        .wr_byte   (wr_byte)
    );

    for (genvar c = 0; c < N_COMP; c++) begin : g_comp
        clut_bank #(.IDX_W(IDX_W)) u_bank (
            .clk   (clk),
            .rst   (rst),
            .we    (comp_we[c]),
            .widx  (wr_idx),
            .wbyte (wr_byte),
            .ridx  (pix_idx),
            .rbyte (pix_rgb[(N_COMP-1-c)*COMP_W +: COMP_W])
        );
    end

endmodule

// File: rtl/clut_loader_chk.sv
module clut_loader_chk
    import clut_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int BUS_W = 32
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     bus_wr,
    input logic [OFS_W-1:0]         bus_addr,
    input logic                     bus_word,
    input logic                     bus_busy,
    input logic [N_COMP*COMP_W-1:0] pix_rgb,
    input logic                     repaint_req
);
    localparam int NB = BUS_W / COMP_W;

    logic acc_col, acc_idx;
    int   busy_run;

    assign acc_col = bus_wr && !bus_busy && (bus_addr == OFS_COLOR);
    assign acc_idx = bus_wr && !bus_busy && (bus_addr == OFS_INDEX);

    always_ff @(posedge clk) begin
        if (rst)           busy_run <= 0;
        else if (bus_busy) busy_run <= busy_run + 1;
        else               busy_run <= 0;
    end

    p_word_busy_r4: assert property (@(posedge clk) disable iff (rst)
        (acc_col && bus_word) |=> bus_busy);

    p_busy_len_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_busy) |-> (busy_run == NB - 1));

    p_byte_nobusy_r2: assert property (@(posedge clk) disable iff (rst)
        (acc_col && !bus_word) |=> !bus_busy);

    p_idx_nobusy_r1: assert property (@(posedge clk) disable iff (rst)
        acc_idx |=> !bus_busy);

    p_repaint_r9: assert property (@(posedge clk) disable iff (rst)
        acc_col |=> repaint_req);

    p_no_repaint_r9: assert property (@(posedge clk) disable iff (rst)
        !acc_col |=> !repaint_req);

    p_reset_r7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pix_rgb == '0 && !bus_busy && !repaint_req));

endmodule

bind clut_loader clut_loader_chk #(.IDX_W(IDX_W), .BUS_W(BUS_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_word    (bus_word),
    .bus_busy    (bus_busy),
    .pix_rgb     (pix_rgb),
    .repaint_req (repaint_req)
);

// File: tb/clut_loader_bench.sv
module clut_loader_bench;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'h0;
    logic        bus_word = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_busy;
    logic [7:0]  pix_idx = '0;
    logic [23:0] pix_rgb;
    logic        repaint_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(PERIOD/2) clk = ~clk;

    clut_loader u_clut_loader (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_busy(bus_busy), .pix_idx(pix_idx), .pix_rgb(pix_rgb),
        .repaint_req(repaint_req)
    );

    // behavioural reference model
    int  m_r[256], m_g[256], m_b[256];
    int  m_idx, m_ph;
    byte unsigned m_q[$];
    logic [23:0] e_rgb;
    bit  e_rep, e_busy, m_valid = 0;

    task automatic m_store(input int v);
        if (m_ph == 0) m_r[m_idx] = v;
        else if (m_ph == 1) m_g[m_idx] = v;
        else m_b[m_idx] = v;
        if (m_ph == 2) begin m_ph = 0; m_idx = (m_idx + 1) % 256; end
        else m_ph = m_ph + 1;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) begin m_r[i] = 0; m_g[i] = 0; m_b[i] = 0; end
            m_idx = 0; m_ph = 0; m_q.delete();
            e_rgb = '0; e_rep = 0; m_valid = 1;
        end else begin
            e_rgb = {8'(m_r[pix_idx]), 8'(m_g[pix_idx]), 8'(m_b[pix_idx])};
            e_rep = 0;
            if (m_q.size() > 0) begin
                m_store(m_q.pop_front());
            end else if (bus_wr) begin
                if (bus_addr == 3'h0) begin
                    m_idx = bus_wdata[7:0]; m_ph = 0;
                end else if (bus_addr == 3'h4) begin
                    e_rep = 1;
                    if (bus_word) begin
                        m_store(bus_wdata[31:24]);
                        m_q.push_back(bus_wdata[23:16]);
                        m_q.push_back(bus_wdata[15:8]);
                        m_q.push_back(bus_wdata[7:0]);
                    end else begin
                        m_store(bus_wdata[7:0]);
                    end
                end
            end
        end
        e_busy = (m_q.size() > 0);
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (m_valid && !done) begin
            chk(32'(pix_rgb), 32'(e_rgb), "R8 colour output");
            chk(32'(bus_busy), 32'(e_busy), "R4 busy");
            chk(32'(repaint_req), 32'(e_rep), "R9 repaint");
            chk(bus_rdata, 32'h0, "R6 read data");
        end
    end

    task automatic wr(input logic [2:0] a, input bit w, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1; bus_addr = a; bus_word = w; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 0;
    endtask

    task automatic settle();
        while (bus_busy) begin @(posedge clk); #1; end
    endtask

    task automatic look(input logic [7:0] i, input logic [23:0] exp, input string tag);
        @(posedge clk); #1; pix_idx = i;
        @(posedge clk); @(negedge clk);
        chk(32'(pix_rgb), 32'(exp), tag);
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R7: reset state
        look(8'd0, 24'h0, "R7 entry 0 after reset");
        look(8'd255, 24'h0, "R7 entry 255 after reset");
        // R1, R2: index then byte rotation
        wr(3'h0, 0, 32'h0000_0005);
        wr(3'h4, 0, 32'hFFFF_FF11);
        wr(3'h4, 0, 32'h0000_0022);
        wr(3'h4, 0, 32'h0000_0033);
        look(8'd5, 24'h112233, "R2 byte rotation entry 5");
        // R3: next byte goes to entry 6 red
        wr(3'h4, 0, 32'h0000_0044);
        look(8'd6, 24'h440000, "R3 auto advance entry 6");
        // R1: index write resets rotation to red
        wr(3'h0, 0, 32'h0000_0006);
        wr(3'h4, 0, 32'h0000_0055);
        look(8'd6, 24'h550000, "R1 rotation back to red");
        // R4, R3: word write with wrap past 255
        wr(3'h0, 0, 32'h0000_00FF);
        wr(3'h4, 1, 32'hAABB_CCDD);
        settle();
        look(8'd255, 24'hAABBCC, "R4 word bytes msb first");
        look(8'd0, 24'hDD0000, "R3 wrap to entry 0");
        // R5: writes while busy are ignored
        wr(3'h0, 0, 32'h0000_0010);
        @(posedge clk); #1;
        bus_wr = 1; bus_addr = 3'h4; bus_word = 1; bus_wdata = 32'h0102_0304;
        @(posedge clk); #1;
        bus_wdata = 32'h0000_0077; bus_word = 0;
        @(posedge clk); #1;
        bus_addr = 3'h0; bus_wdata = 32'h0000_0020;
        @(posedge clk); #1;
        bus_wr = 0;
        settle();
        look(8'd16, 24'h010203, "R5 busy writes leave entry 16");
        look(8'd17, 24'h040000, "R5 busy writes leave entry 17");
        look(8'd32, 24'h000000, "R5 busy index write ignored");
        // R8: same-cycle write and lookup returns old value
        wr(3'h0, 0, 32'h0000_0040);
        @(posedge clk); #1;
        pix_idx = 8'h40; bus_wr = 1; bus_addr = 3'h4; bus_word = 0; bus_wdata = 32'h99;
        @(posedge clk); #1; bus_wr = 0;
        @(negedge clk);
        chk(32'(pix_rgb), 32'h0, "R8 old value on same-cycle write");
        look(8'h40, 24'h990000, "R8 new value next lookup");
        // random phase
        for (int n = 0; n < 3000; n++) begin
            @(posedge clk); #1;
            bus_wr    = ($urandom % 3) != 0;
            bus_addr  = ($urandom % 5 == 0) ? 3'($urandom) : (($urandom % 4 == 0) ? 3'h0 : 3'h4);
            bus_word  = $urandom % 2;
            bus_wdata = $urandom;
            pix_idx   = 8'($urandom);
        end
        @(posedge clk); #1; bus_wr = 0;
        settle();
        // R7: mid-run reset clears palette
        @(posedge clk); #1 rst = 1;
        @(posedge clk); #1 rst = 0;
        look(8'h40, 24'h0, "R7 palette cleared by reset");
        look(8'd5, 24'h0, "R7 entry 5 cleared by reset");
        repeat (3) @(posedge clk);
        finish_run();
    end

endmodule